// File: doc/BRIEF.md
# Queued Command-Word SPI Master

This block is an SPI master driven entirely by 32-bit command words. Software writes each command into a push register, which feeds a four-entry transmit queue; the engine takes one command at a time and shifts out one frame. The frame is 4 to 16 bits long, and each command names its own chip select, one of four attribute sets, whether chip select stays asserted after the frame, and whether the frame closes the queue. Each received frame is stored in a four-entry receive queue, and software reads it back through a pop register.

Half-period timing comes from an external strobe, `half_tick`. The engine advances one serial-clock half period for each cycle in which the strobe is high. The block keeps a 16-bit count of transmitted frames. It raises a transfer-complete flag and an end-of-queue flag; each flag can drive the interrupt output. While the end-of-queue flag is set, no new frame starts, so software can refill the queue and then release the engine.

Top module: `spiq_master`

## Requirements
- R1: After reset, status (word address 1), frame count (word address 3) and pop (word address 5) all read 0. `pcs`, `irq` and `sck` are low.
- R2: A write to the push register (word address 4) enters the transmit queue, which holds 4 commands. A push while the queue is full is ignored, and that command is never transmitted.
- R3: A frame is (attribute bits 30:27) + 1 bits long. Attribute bit 26 is the clock idle level. Bit 25 set means sample on the trailing edge instead of the leading edge. Bit 24 set sends the LSB first. The attribute set comes from command bits 29:28 and lives at word address 8 + set. Command bits 15:0 are the transmit data.
- R4: Each received frame is queued, 4 deep, zero-extended. Reading word address 5 returns the oldest entry in bits 15:0 and removes it. A read while the queue is empty returns 0.
- R5: Command bits 21:16 pick the chip-select lines. Control bits 21:16 (word address 0) set the idle level of each line, and a selected line drives the opposite level.
- R6: Chip select after a frame depends on command bit 31. If bit 31 is 0, chip select stays active for `AFTER_HT` half periods and is then released. If bit 31 is 1, chip select stays active into the next frame, or until one arrives.
- R7: When a frame with command bit 27 set finishes, the end-of-queue flag (status bit 28) is set. No new frame starts until software clears that flag.
- R8: Every finished frame sets the transfer-complete flag (status bit 31). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: The frame count in bits 31:16 of word address 3 increases by one per finished frame and wraps modulo 65536. Command bit 26 clears the count before that frame is sent.
- R10: `irq` is high while any status flag is set and the enable bit at the same position (word address 2) is also set.
- R11: Writing control bit 11 empties the transmit queue, and writing control bit 10 empties the receive queue. Control bit 31 must be 1 for any frame to start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | AW | Word address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (pops the receive queue at address 5) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| half_tick | input | 1 | Half-period strobe from the timing generator |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pcs | output | 6 | Chip-select lines |
| irq | output | 1 | Interrupt request |

## Verification
With `half_tick` held high, a push is in the queue at the next edge. The engine takes a command on the first idle cycle after it arrives. It then spends one setup cycle and 2N shifting cycles. Flags, the count and the receive entry all update at the edge that ends the last half period, and chip select is released `AFTER_HT` cycles later. Because of this, the checks do not predict exact edges for multi-frame sequences. They poll the end-of-queue flag with a timeout and read registers only after it is set. A falling-edge serial monitor rebuilds each frame bit by bit and compares it against a queue of expected frames. Checks that something must not happen wait out a fixed margin of many frame times first.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int DATA_W    = 16;
  localparam int NCS       = 6;
  localparam int NSETS     = 4;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_STAT  = 1;
  localparam int ADR_IEN   = 2;
  localparam int ADR_TCNT  = 3;
  localparam int ADR_PUSH  = 4;
  localparam int ADR_POP   = 5;
  localparam int ADR_ATTR0 = 8;

  typedef struct packed {
    logic              hold_cs;
    logic              rsv_a;
    logic [1:0]        set_sel;
    logic              last;
    logic              cnt_clr;
    logic [3:0]        rsv_b;
    logic [NCS-1:0]    cs;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef struct packed {
    logic [3:0] fsz;
    logic       cpol;
    logic       cpha;
    logic       lsb_first;
  } attr_t;

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_SHIFT, E_AFTER} eng_st_t;

  // frame length in bits; codes below 3 fall back to the 4-bit minimum
  function automatic logic [4:0] frame_len(input logic [3:0] fsz);
    return (fsz < 4'd3) ? 5'd4 : ({1'b0, fsz} + 5'd1);
  endfunction

  // data bit position of the idx-th bit on the wire
  function automatic logic [3:0] bit_pos(input logic [3:0] idx,
                                         input logic [4:0] nbits,
                                         input logic lsb);
    logic [4:0] t;
    t = nbits - 5'd1 - {1'b0, idx};
    return lsb ? idx : t[3:0];
  endfunction
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end
endmodule

// File: rtl/spiq_engine.sv
module spiq_engine
  import spiq_pkg::*;
#(
  parameter int AFTER_HT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       tick,
  input  logic                       cmd_valid,
  input  cmd_t                       cmd_in,
  input  attr_t [NSETS-1:0]          attr_sets,
  input  logic                       miso,
  output logic                       cmd_take,
  output logic                       sck,
  output logic                       mosi,
  output logic                       cs_on,
  output logic [NCS-1:0]             cs_sel,
  output logic                       frame_done,
  output logic                       frame_last,
  output logic [DATA_W-1:0]          rx_word,
  output logic [15:0]                tcnt
);
  localparam int ACW = $clog2(AFTER_HT + 1);

  eng_st_t           state;
  attr_t             cur, pick;
  logic [4:0]        nbits;
  logic [5:0]        hcnt, last_h;
  logic [3:0]        out_idx, in_idx;
  logic [DATA_W-1:0] tx_data, rx_sh, rx_next;
  logic              keep_cs;
  logic [ACW-1:0]    after_cnt;
  logic              sample_now, shift_now;
  logic              unused_cmd;

  assign unused_cmd = ^{cmd_in.rsv_a, cmd_in.rsv_b};
  assign pick       = attr_sets[cmd_in.set_sel];
  assign cmd_take   = (state == E_IDLE) && run && cmd_valid;
  assign last_h     = {nbits, 1'b0} - 6'd1;
  assign sample_now = (state == E_SHIFT) && tick && (hcnt[0] == cur.cpha);
  assign shift_now  = (state == E_SHIFT) && tick && (hcnt[0] != cur.cpha) && (hcnt != 6'd0);
  assign frame_done = (state == E_SHIFT) && tick && (hcnt == last_h);
  assign mosi       = cs_on & tx_data[bit_pos(out_idx, nbits, cur.lsb_first)];
  assign rx_word    = rx_next;

  always_comb begin
    rx_next = rx_sh;
    if (sample_now) rx_next[bit_pos(in_idx, nbits, cur.lsb_first)] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= E_IDLE; cur <= '0; nbits <= 5'd4; hcnt <= '0;
      out_idx <= '0; in_idx <= '0; tx_data <= '0; rx_sh <= '0;
      sck <= 1'b0; cs_on <= 1'b0; cs_sel <= '0; keep_cs <= 1'b0;
      frame_last <= 1'b0; after_cnt <= '0; tcnt <= '0;
    end else begin
      case (state)
        E_IDLE: if (cmd_take) begin
          cur        <= pick;
          nbits      <= frame_len(pick.fsz);
          tx_data    <= cmd_in.data;
          keep_cs    <= cmd_in.hold_cs;
          frame_last <= cmd_in.last;
          sck        <= pick.cpol;
          cs_on      <= 1'b1;
          cs_sel     <= cmd_in.cs;
          hcnt       <= '0;
          out_idx    <= '0;
          in_idx     <= '0;
          rx_sh      <= '0;
          if (cmd_in.cnt_clr) tcnt <= '0;
          state      <= E_SETUP;
        end
        E_SETUP: if (tick) state <= E_SHIFT;
        E_SHIFT: if (tick) begin
          sck  <= ~sck;
          hcnt <= hcnt + 6'd1;
          if (sample_now) begin
            rx_sh  <= rx_next;
            in_idx <= in_idx + 4'd1;
          end
          if (shift_now) out_idx <= out_idx + 4'd1;
          if (frame_done) begin
            tcnt <= tcnt + 16'd1;
            if (keep_cs) state <= E_IDLE;
            else begin
              state     <= E_AFTER;
              after_cnt <= '0;
            end
          end
        end
        E_AFTER: if (tick) begin
          if (after_cnt == ACW'(AFTER_HT - 1)) begin
            cs_on <= 1'b0;
            state <= E_IDLE;
          end else begin
            after_cnt <= after_cnt + 1'b1;
          end
        end
        default: state <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spiq_master.sv
module spiq_master
  import spiq_pkg::*;
#(
  parameter int AW         = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int AFTER_HT   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          half_tick,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic [5:0]    pcs,
  output logic          irq
);
  logic              master_en, flag_tcf, flag_eoq, en_tcf, en_eoq;
  logic [NCS-1:0]    idle_lvl, cs_sel;
  attr_t [NSETS-1:0] attr_r;
  logic              wr_ctrl, wr_stat, wr_ien, push_req, pop_req;
  logic              flush_tx, flush_rx, push_drop, run;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [31:0]       tx_head;
  logic [DATA_W-1:0] rx_head, rx_word;
  logic              cmd_take, cs_on, frame_done, frame_last;
  logic [15:0]       tcnt;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata[30:29], reg_wdata[27:22], reg_wdata[15:12],
                          reg_wdata[9:0], rx_full};

  assign wr_ctrl   = reg_wr && (reg_addr == AW'(ADR_CTRL));
  assign wr_stat   = reg_wr && (reg_addr == AW'(ADR_STAT));
  assign wr_ien    = reg_wr && (reg_addr == AW'(ADR_IEN));
  assign push_req  = reg_wr && (reg_addr == AW'(ADR_PUSH));
  assign pop_req   = reg_rd && (reg_addr == AW'(ADR_POP));
  assign flush_tx  = wr_ctrl && reg_wdata[11];
  assign flush_rx  = wr_ctrl && reg_wdata[10];
  assign push_drop = push_req && tx_full;
  assign run       = master_en && !flag_eoq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_en <= 1'b0; idle_lvl <= '0;
      flag_tcf <= 1'b0; flag_eoq <= 1'b0;
      en_tcf <= 1'b0; en_eoq <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        master_en <= reg_wdata[31];
        idle_lvl  <= reg_wdata[21:16];
      end
      if (wr_ien) begin
        en_tcf <= reg_wdata[31];
        en_eoq <= reg_wdata[28];
      end
      flag_tcf <= frame_done | (flag_tcf & ~(wr_stat & reg_wdata[31]));
      flag_eoq <= (frame_done & frame_last) | (flag_eoq & ~(wr_stat & reg_wdata[28]));
    end
  end

  for (genvar g = 0; g < NSETS; g++) begin : g_attr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) attr_r[g] <= '0;
      else if (reg_wr && reg_addr == AW'(ADR_ATTR0 + g)) attr_r[g] <= reg_wdata[30:24];
    end
  end

  spiq_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush_tx), .push(push_req), .wdata(reg_wdata),
    .pop(cmd_take), .rdata(tx_head), .full(tx_full), .empty(tx_empty));

  spiq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush_rx), .push(frame_done), .wdata(rx_word),
    .pop(pop_req), .rdata(rx_head), .full(rx_full), .empty(rx_empty));

  spiq_engine #(.AFTER_HT(AFTER_HT)) i_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(half_tick), .cmd_valid(!tx_empty),
    .cmd_in(cmd_t'(tx_head)), .attr_sets(attr_r), .miso(miso), .cmd_take(cmd_take),
    .sck(sck), .mosi(mosi), .cs_on(cs_on), .cs_sel(cs_sel), .frame_done(frame_done),
    .frame_last(frame_last), .rx_word(rx_word), .tcnt(tcnt));

  assign pcs = cs_on ? (idle_lvl ^ cs_sel) : idle_lvl;
  assign irq = (flag_tcf & en_tcf) | (flag_eoq & en_eoq);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(ADR_CTRL))      reg_rdata = {master_en, 9'd0, idle_lvl, 16'd0};
    else if (reg_addr == AW'(ADR_STAT)) reg_rdata = {flag_tcf, 2'b00, flag_eoq, 28'd0};
    else if (reg_addr == AW'(ADR_IEN))  reg_rdata = {en_tcf, 2'b00, en_eoq, 28'd0};
    else if (reg_addr == AW'(ADR_TCNT)) reg_rdata = {tcnt, 16'd0};
    else if (reg_addr == AW'(ADR_POP))  reg_rdata = {16'd0, rx_empty ? 16'd0 : rx_head};
    for (int g = 0; g < NSETS; g++)
      if (reg_addr == AW'(ADR_ATTR0 + g)) reg_rdata = {1'b0, attr_r[g], 24'd0};
  end
endmodule

// File: rtl/spiq_checker.sv
module spiq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        push_drop,
  input logic        tx_full,
  input logic        cmd_take,
  input logic        flag_eoq,
  input logic        flag_tcf,
  input logic        frame_done,
  input logic [15:0] tcnt,
  input logic        pop_req,
  input logic        rx_empty,
  input logic [31:0] reg_rdata,
  input logic        cs_on,
  input logic [5:0]  pcs,
  input logic [5:0]  idle_lvl
);
  // R2
  drop_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !cmd_take) |=> tx_full);
  // R7
  eoq_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_eoq |-> !cmd_take);
  // R9
  tcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (tcnt == $past(tcnt) + 16'd1));
  // R8
  tcf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> flag_tcf);
  // R4
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && rx_empty) |-> (reg_rdata == 32'd0));
  // R5
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcs != idle_lvl) |-> cs_on);
endmodule

bind spiq_master spiq_checker i_chk (
  .clk(clk), .rst_n(rst_n), .push_drop(push_drop), .tx_full(tx_full),
  .cmd_take(cmd_take), .flag_eoq(flag_eoq), .flag_tcf(flag_tcf),
  .frame_done(frame_done), .tcnt(tcnt), .pop_req(pop_req), .rx_empty(rx_empty),
  .reg_rdata(reg_rdata), .cs_on(cs_on), .pcs(pcs), .idle_lvl(idle_lvl));

// File: tb/test_spiq_master.sv
`timescale 1ns/1ps
module test_spiq_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic        wr, rd;
  logic [31:0] wdata, rdata;
  logic        sck, mosi, miso;
  logic [5:0]  pcs;
  logic        irq;

  always #5 clk = ~clk;
  assign miso = mosi;

  spiq_master i_spiq_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .half_tick(1'b1), .sck(sck),
    .mosi(mosi), .miso(miso), .pcs(pcs), .irq(irq));

  typedef struct packed {
    logic [15:0] d;
    logic [5:0]  cs;
    logic [4:0]  n;
    logic        cpol, cpha, lsb;
  } exp_t;

  exp_t        exp_q[$];
  int          nchk = 0, nerr = 0, cyc = 0, rel_cnt = 0;
  bit          done = 0;
  logic [5:0]  inact = 6'h00;
  logic        prev_sck = 1'b0, prev_act = 1'b0;
  logic [15:0] mon_word = '0;
  int          mon_idx = 0;

  localparam logic [6:0] AT0 = 7'b0111_000; // 8 bit, idle low, leading, MSB
  localparam logic [6:0] AT1 = 7'b1111_111; // 16 bit, idle high, trailing, LSB
  localparam logic [6:0] AT2 = 7'b1011_010; // 12 bit, idle low, trailing, MSB
  localparam logic [6:0] AT3 = 7'b0011_101; // 4 bit, idle high, leading, LSB

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    addr = 4'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    addr = 4'(a); rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [31:0] mk(input bit cont, input logic [1:0] sel, input bit last,
                                     input bit clr, input int csi, input logic [15:0] d);
    return {cont, 1'b0, sel, last, clr, 4'b0, 6'(1 << csi), d};
  endfunction

  // driver: records the frame the monitor must see, then pushes the command
  task automatic send(input logic [31:0] w, input logic [6:0] at, input bit expect_it);
    exp_t e;
    logic [4:0] n;
    n = {1'b0, at[6:3]} + 5'd1;
    e.n = n; e.cpol = at[2]; e.cpha = at[1]; e.lsb = at[0];
    e.cs = w[21:16];
    e.d = w[15:0] & 16'((32'd1 << n) - 1);
    if (expect_it) exp_q.push_back(e);
    reg_wr(4, w);
  endtask

  task automatic wait_eoq(input string req);
    logic [31:0] s;
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      reg_rd(1, s);
      if (s[28]) seen = 1;
    end
    if (!seen) check(req, 32'd0, 32'd1);
  endtask

  task automatic expect_pop(input string req, input logic [15:0] v);
    logic [31:0] d;
    reg_rd(5, d);
    check(req, d, {16'd0, v});
  endtask

  // monitor: rebuilds frames from the wire and compares with the scoreboard
  always @(negedge clk) begin
    logic [5:0] act;
    logic lead;
    exp_t it;
    act = pcs ^ inact;
    if (rst_n && (|act) && prev_act && (sck != prev_sck) && exp_q.size() > 0) begin
      it = exp_q[0];
      lead = (prev_sck == it.cpol);
      if (lead == !it.cpha) begin
        if (it.lsb) mon_word[mon_idx] = mosi;
        else        mon_word[int'(it.n) - 1 - mon_idx] = mosi;
        mon_idx++;
        if (mon_idx == int'(it.n)) begin
          check("R3 frame on wire", {10'd0, act, mon_word}, {10'd0, it.cs, it.d});
          void'(exp_q.pop_front());
          mon_idx = 0;
          mon_word = '0;
        end
      end
    end
    if (prev_act && !(|act)) rel_cnt++;
    prev_sck = sck;
    prev_act = |act;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c0;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(1, d); check("R1 status", d, 32'd0);
    reg_rd(3, d); check("R1 count", d, 32'd0);
    reg_rd(5, d); check("R1 pop", d, 32'd0);
    check("R1 pins", {29'd0, |pcs, irq, sck}, 32'd0);

    reg_wr(0, 32'h803F_0000);
    inact = 6'h3F;
    check("R5 idle level", {26'd0, pcs}, 32'h3F);
    reg_wr(8,  {1'b0, AT0, 24'd0});
    reg_wr(9,  {1'b0, AT1, 24'd0});
    reg_wr(10, {1'b0, AT2, 24'd0});
    reg_wr(11, {1'b0, AT3, 24'd0});
    reg_rd(9, d); check("R3 attr readback", d, 32'h7F00_0000);

    // basic 8-bit queue
    send(mk(0, 2'd0, 0, 0, 0, 16'h00A5), AT0, 1);
    send(mk(0, 2'd0, 0, 0, 0, 16'h003C), AT0, 1);
    send(mk(0, 2'd0, 1, 0, 0, 16'h000F), AT0, 1);
    wait_eoq("R7 eoq basic");
    reg_rd(3, d); check("R9 count 3", d, 32'h0003_0000);
    expect_pop("R4 pop 1", 16'h00A5);
    expect_pop("R4 pop 2", 16'h003C);
    expect_pop("R4 pop 3", 16'h000F);
    expect_pop("R4 pop empty", 16'h0000);
    reg_rd(1, d); check("R8 flags set", d, 32'h9000_0000);
    reg_wr(1, 32'h9000_0000);
    reg_rd(1, d); check("R8 w1c", d, 32'd0);

    // modes and attribute sets
    send(mk(0, 2'd1, 0, 0, 1, 16'hBEEF), AT1, 1);
    send(mk(0, 2'd2, 0, 0, 3, 16'h0ABC), AT2, 1);
    send(mk(0, 2'd3, 1, 0, 5, 16'h00F9), AT3, 1);
    wait_eoq("R7 eoq modes");
    expect_pop("R3 16-bit echo", 16'hBEEF);
    expect_pop("R3 12-bit echo", 16'h0ABC);
    expect_pop("R3 4-bit echo", 16'h0009);
    reg_wr(1, 32'h9000_0000);

    // continuous chip select
    repeat (6) @(negedge clk);
    rel_cnt = 0;
    send(mk(1, 2'd0, 0, 0, 2, 16'h0011), AT0, 1);
    send(mk(1, 2'd0, 1, 0, 2, 16'h0022), AT0, 1);
    wait_eoq("R7 eoq cont");
    repeat (6) @(negedge clk);
    check("R6 held between frames", rel_cnt, 0);
    check("R6 held after queue", {26'd0, pcs}, 32'h3B);
    reg_wr(1, 32'h9000_0000);
    send(mk(0, 2'd0, 1, 0, 2, 16'h0033), AT0, 1);
    wait_eoq("R7 eoq release");
    repeat (6) @(negedge clk);
    check("R6 released once", rel_cnt, 1);
    check("R6 idle after release", {26'd0, pcs}, 32'h3F);
    expect_pop("R4 cont 1", 16'h0011);
    expect_pop("R4 cont 2", 16'h0022);
    expect_pop("R4 cont 3", 16'h0033);
    reg_wr(1, 32'h9000_0000);

    // end-of-queue halt
    reg_rd(3, c0);
    send(mk(0, 2'd0, 1, 0, 0, 16'h0044), AT0, 1);
    send(mk(0, 2'd0, 1, 0, 0, 16'h0055), AT0, 1);
    wait_eoq("R7 eoq halt");
    repeat (80) @(negedge clk);
    reg_rd(3, d); check("R7 halted", d, c0 + 32'h0001_0000);
    reg_wr(1, 32'h1000_0000);
    wait_eoq("R7 eoq resume");
    reg_rd(3, d); check("R7 resumed", d, c0 + 32'h0002_0000);
    expect_pop("R4 halt 1", 16'h0044);
    expect_pop("R4 halt 2", 16'h0055);
    reg_wr(1, 32'h9000_0000);

    // full queue drops fifth push
    reg_rd(3, c0);
    reg_wr(0, 32'h003F_0000);
    send(mk(0, 2'd0, 0, 0, 1, 16'h0001), AT0, 1);
    send(mk(0, 2'd0, 0, 0, 1, 16'h0002), AT0, 1);
    send(mk(0, 2'd0, 0, 0, 1, 16'h0003), AT0, 1);
    send(mk(0, 2'd0, 1, 0, 1, 16'h0004), AT0, 1);
    send(mk(0, 2'd0, 1, 0, 1, 16'h0005), AT0, 0);
    repeat (40) @(negedge clk);
    reg_rd(3, d); check("R11 master off", d, c0);
    reg_wr(0, 32'h803F_0000);
    wait_eoq("R7 eoq full");
    repeat (80) @(negedge clk);
    reg_rd(3, d); check("R2 four sent", d, c0 + 32'h0004_0000);
    expect_pop("R2 full 1", 16'h0001);
    expect_pop("R2 full 2", 16'h0002);
    expect_pop("R2 full 3", 16'h0003);
    expect_pop("R2 full 4", 16'h0004);
    expect_pop("R2 fifth dropped", 16'h0000);
    reg_wr(1, 32'h9000_0000);

    // counter clear in command
    send(mk(0, 2'd0, 1, 1, 0, 16'h0066), AT0, 1);
    wait_eoq("R7 eoq clr");
    reg_rd(3, d); check("R9 cleared then one", d, 32'h0001_0000);
    expect_pop("R4 clr", 16'h0066);
    reg_wr(1, 32'h9000_0000);

    // flushes
    reg_rd(3, c0);
    reg_wr(0, 32'h003F_0000);
    send(mk(0, 2'd0, 0, 0, 0, 16'h0077), AT0, 0);
    send(mk(0, 2'd0, 1, 0, 0, 16'h0078), AT0, 0);
    reg_wr(0, 32'h003F_0800);
    reg_wr(0, 32'h803F_0000);
    repeat (80) @(negedge clk);
    reg_rd(3, d); check("R11 tx flush count", d, c0);
    reg_rd(1, d); check("R11 tx flush status", d, 32'd0);
    send(mk(0, 2'd0, 1, 0, 0, 16'h0079), AT0, 1);
    wait_eoq("R7 eoq flush");
    reg_wr(0, 32'h803F_0400);
    expect_pop("R11 rx flush", 16'h0000);
    reg_wr(1, 32'h9000_0000);

    // interrupt
    reg_wr(2, 32'h8000_0000);
    check("R10 irq idle", {31'd0, irq}, 32'd0);
    send(mk(0, 2'd0, 1, 0, 4, 16'h007A), AT0, 1);
    wait_eoq("R7 eoq irq");
    check("R10 irq raised", {31'd0, irq}, 32'd1);
    reg_wr(1, 32'h8000_0000);
    check("R10 irq cleared", {31'd0, irq}, 32'd0);
    reg_rd(1, d); check("R8 only tcf cleared", d, 32'h1000_0000);
    expect_pop("R4 irq frame", 16'h007A);

    repeat (20) @(negedge clk);
    check("R3 all frames seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule